// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block performs integer multiplication and division one bit per clock and keeps its results in two result registers, HI and LO. A caller pulses `start` while the unit is idle and presents a two-bit operation code with two operands. The unit accepts that request, raises `busy` for the length of the computation, and then pulses `done` for one cycle. In that same cycle HI and LO take their new values together.

A multiply leaves the double-width product split across the pair, with the upper word in HI and the lower word in LO. A divide leaves the quotient in LO and the remainder in HI. Signed and unsigned forms share one shift-and-add / shift-and-subtract datapath. Signed requests are reduced to magnitudes on entry, and the signs are restored on exit. Neither operation flags an overflow. HI and LO are driven straight out on two read ports, so a pipeline can copy either word to a general register at any time without any arithmetic.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 2'b00 is signed multiply: {HI, LO} receives the full two's-complement product of A and B.
- R2: Operation code 2'b01 is unsigned multiply: {HI, LO} receives the full unsigned product of A and B.
- R3: Operation code 2'b10 is signed divide. LO receives the quotient, truncated toward zero. HI receives the remainder, which carries the sign of the dividend. The most negative dividend divided by -1 gives LO = 32'h8000_0000 and HI = 0, with no error.
- R4: Operation code 2'b11 is unsigned divide: LO receives A / B and HI receives A mod B.
- R5: A `start` sampled while `busy` is low is accepted. `busy` is then high for exactly 32 cycles, after which `done` is high for exactly one cycle with `busy` low.
- R6: A `start` sampled while `busy` is high is ignored. The running operation keeps its operands, its timing and its result.
- R7: HI and LO hold their values in every cycle except the one in which `done` rises, and they change together at that edge.
- R8: Unsigned divide by zero still takes 32 cycles. It leaves LO all ones and HI equal to the dividend.
- R9: Signed divide by zero takes 32 cycles and leaves HI equal to the dividend. LO becomes 32'h0000_0001 when the dividend is negative and all ones otherwise.
- R10: During and right after reset, `busy` and `done` are low and HI and LO are zero.
- R11: A `start` presented in the cycle where `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse, sampled when the unit is idle |
| op | input | 2 | Operation code (see R1 to R4) |
| opa | input | 32 | First operand: multiplicand or dividend |
| opb | input | 32 | Second operand: multiplier or divisor |
| busy | output | 1 | High while the iteration runs |
| done | output | 1 | One-cycle completion pulse |
| hi_out | output | 32 | Read port for HI |
| lo_out | output | 32 | Read port for LO |

## Verification
The assertions assume that `start` is a clean synchronous level. They also assume that `op`, `opa` and `opb` are valid whenever `start` is sampled while the unit is idle, and that `rst_n` is held low for at least one rising edge. The bench drives every input on the falling clock edge and keeps reset low for several cycles. It issues requests only in idle or done cycles, except for deliberate start pulses in the busy window that test that such pulses are ignored. Divide-by-zero and most-negative-operand cases are applied directly, since those are the inputs on which the sign and zero-divisor assertions rely.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   typedef enum logic [1:0] {
      OP_MUL_S = 2'b00,
      OP_MUL_U = 2'b01,
      OP_DIV_S = 2'b10,
      OP_DIV_U = 2'b11
   } md_op_e;

   function automatic logic op_is_div(input logic [1:0] code);
      return code[1];
   endfunction

   function automatic logic op_is_signed(input logic [1:0] code);
      return ~code[0];
   endfunction

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl #(
   parameter int DATA_W = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic last,
   output logic busy,
   output logic done
);
   localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(DATA_W - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          done_q;

   assign load = start && !busy_q;
   assign step = busy_q;
   assign last = busy_q && (cnt_q == LAST_CNT);
   assign busy = busy_q;
   assign done = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         done_q <= last;
         if (load) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (last) begin
            busy_q <= 1'b0;
         end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R5: busy only ends by handing over to done
   assert_busy_ends_in_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> busy);
   assert_done_follows_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R6: a start in the busy window never restarts the count
   assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (cnt_q != '0));

endmodule

// File: rtl/muldiv_presign.sv
module muldiv_presign
   import muldiv_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] mag_a,
   output logic [DATA_W-1:0] mag_b,
   output logic              neg_main,
   output logic              neg_rem,
   output logic              is_div,
   output logic              div_zero
);
   logic sgn_a, sgn_b;

   always_comb begin
      sgn_a    = op_is_signed(op) & opa[DATA_W-1];
      sgn_b    = op_is_signed(op) & opb[DATA_W-1];
      mag_a    = sgn_a ? (~opa + 1'b1) : opa;
      mag_b    = sgn_b ? (~opb + 1'b1) : opb;
      is_div   = op_is_div(op);
      neg_main = sgn_a ^ sgn_b;
      neg_rem  = is_div & sgn_a;
      div_zero = (opb == '0);
   end

endmodule

// File: rtl/muldiv_core.sv
module muldiv_core #(
   parameter int DATA_W       = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              is_div,
   input  logic [DATA_W-1:0] mag_a,
   input  logic [DATA_W-1:0] mag_b,
   output logic [DATA_W-1:0] nxt_hi,
   output logic [DATA_W-1:0] nxt_lo
);
   localparam int AW = DATA_W + 2;

   logic [DATA_W-1:0] hi_r, lo_r, opnd_r;
   logic [AW-1:0]     res;
   logic              fits;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [AW-1:0] x_in, y_in;
         logic          sub;
         always_comb begin
            if (is_div) begin
               x_in = {1'b0, hi_r, lo_r[DATA_W-1]};
               y_in = {2'b00, opnd_r};
               sub  = 1'b1;
            end else begin
               x_in = {2'b00, hi_r};
               y_in = lo_r[0] ? {2'b00, opnd_r} : '0;
               sub  = 1'b0;
            end
         end
         assign res = x_in + (y_in ^ {AW{sub}}) + AW'(sub);
      end else begin : g_split
         logic [AW-1:0] add_v, sub_v;
         assign add_v = {2'b00, hi_r} + (lo_r[0] ? {2'b00, opnd_r} : '0);
         assign sub_v = {1'b0, hi_r, lo_r[DATA_W-1]} - {2'b00, opnd_r};
         assign res   = is_div ? sub_v : add_v;
      end
   endgenerate

   assign fits = ~res[AW-1];

   always_comb begin
      if (is_div) begin
         nxt_hi = fits ? res[DATA_W-1:0] : {hi_r[DATA_W-2:0], lo_r[DATA_W-1]};
         nxt_lo = {lo_r[DATA_W-2:0], fits};
      end else begin
         nxt_hi = res[DATA_W:1];
         nxt_lo = {res[0], lo_r[DATA_W-1:1]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_r   <= '0;
         lo_r   <= '0;
         opnd_r <= '0;
      end else if (load) begin
         hi_r   <= '0;
         lo_r   <= mag_a;
         opnd_r <= mag_b;
      end else if (step) begin
         hi_r <= nxt_hi;
         lo_r <= nxt_lo;
      end
   end

   // R4: the partial remainder stays below a nonzero divisor
   assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && is_div && opnd_r != '0) |=> (hi_r < opnd_r));

endmodule

// File: rtl/muldiv_postsign.sv
module muldiv_postsign #(
   parameter int DATA_W = 32
) (
   input  logic              is_div,
   input  logic              neg_main,
   input  logic              neg_rem,
   input  logic [DATA_W-1:0] raw_hi,
   input  logic [DATA_W-1:0] raw_lo,
   output logic [DATA_W-1:0] fix_hi,
   output logic [DATA_W-1:0] fix_lo
);
   logic [2*DATA_W-1:0] prod;

   always_comb begin
      prod = {raw_hi, raw_lo};
      if (neg_main) prod = ~prod + 1'b1;
      if (is_div) begin
         fix_lo = neg_main ? (~raw_lo + 1'b1) : raw_lo;
         fix_hi = neg_rem  ? (~raw_hi + 1'b1) : raw_hi;
      end else begin
         fix_hi = prod[2*DATA_W-1:DATA_W];
         fix_lo = prod[DATA_W-1:0];
      end
   end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
   import muldiv_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] hi_out,
   output logic [DATA_W-1:0] lo_out
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("muldiv_unit: DATA_W must be at least 2");
      end
   endgenerate

   logic              load, step, last;
   logic [DATA_W-1:0] mag_a, mag_b, nxt_hi, nxt_lo, fix_hi, fix_lo;
   logic              neg_main, neg_rem, is_div, div_zero;
   logic              neg_main_q, neg_rem_q, is_div_q, div_zero_q;
   logic [1:0]        op_q;
   logic [DATA_W-1:0] hi_q, lo_q;

   muldiv_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load(load), .step(step), .last(last), .busy(busy), .done(done)
   );

   muldiv_presign #(.DATA_W(DATA_W)) u_pre (
      .op(op), .opa(opa), .opb(opb),
      .mag_a(mag_a), .mag_b(mag_b), .neg_main(neg_main), .neg_rem(neg_rem),
      .is_div(is_div), .div_zero(div_zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         neg_main_q <= 1'b0;
         neg_rem_q  <= 1'b0;
         is_div_q   <= 1'b0;
         div_zero_q <= 1'b0;
         op_q       <= OP_MUL_S;
      end else if (load) begin
         neg_main_q <= neg_main;
         neg_rem_q  <= neg_rem;
         is_div_q   <= is_div;
         div_zero_q <= div_zero;
         op_q       <= op;
      end
   end

   muldiv_core #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_core (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step), .is_div(is_div_q),
      .mag_a(mag_a), .mag_b(mag_b), .nxt_hi(nxt_hi), .nxt_lo(nxt_lo)
   );

   muldiv_postsign #(.DATA_W(DATA_W)) u_post (
      .is_div(is_div_q), .neg_main(neg_main_q), .neg_rem(neg_rem_q),
      .raw_hi(nxt_hi), .raw_lo(nxt_lo), .fix_hi(fix_hi), .fix_lo(fix_lo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (last) begin
         hi_q <= fix_hi;
         lo_q <= fix_lo;
      end
   end

   assign hi_out = hi_q;
   assign lo_out = lo_q;

   // R7: result registers move only with the completion pulse
   assert_hold_results_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(hi_q) && $stable(lo_q)));
   // R8: unsigned divide by zero fills the quotient with ones
   assert_divzero_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == OP_DIV_U && div_zero_q) |-> (lo_q == '1));
   // R10: no completion without a preceding busy window
   assert_no_spurious_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> !done);

endmodule

// File: tb/muldiv_unit_test.sv
`timescale 1ns/1ps
module muldiv_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [31:0] opa = '0, opb = '0;
   logic        busy, done;
   logic [31:0] hi_out, lo_out;

   int unsigned checks = 0;
   int unsigned bad = 0;
   bit          running = 1'b0;
   string       cur_tag = "R1";

   // reference model state
   bit          m_busy, m_done;
   int          m_cnt;
   logic [31:0] m_hi, m_lo, p_hi, p_lo;

   muldiv_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
      .busy(busy), .done(done), .hi_out(hi_out), .lo_out(lo_out)
   );

   always #10 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic void calc(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b,
                                output logic [31:0] h, output logic [31:0] l);
      longint      sa, sb, q, r;
      logic [63:0] p;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      case (c)
         2'b00: begin p = 64'(sa * sb); h = p[63:32]; l = p[31:0]; end
         2'b01: begin p = {32'b0, a} * {32'b0, b}; h = p[63:32]; l = p[31:0]; end
         2'b10: begin
            if (b == 0) begin h = a; l = a[31] ? 32'h1 : 32'hFFFF_FFFF; end
            else begin q = sa / sb; r = sa % sb; l = q[31:0]; h = r[31:0]; end
         end
         default: begin
            if (b == 0) begin h = a; l = 32'hFFFF_FFFF; end
            else begin l = a / b; h = a % b; end
         end
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_cnt = 0; m_hi = '0; m_lo = '0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_cnt++;
            if (m_cnt == 32) begin
               m_busy = 0; m_done = 1; m_hi = p_hi; m_lo = p_lo;
            end
         end else if (start) begin
            m_busy = 1; m_cnt = 0;
            calc(op, opa, opb, p_hi, p_lo);
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && running) begin
         chk("R5 busy", {31'b0, busy}, {31'b0, m_busy});
         chk("R5 done", {31'b0, done}, {31'b0, m_done});
         chk(m_busy ? "R7 hi" : {cur_tag, " hi"}, hi_out, m_hi);
         chk(m_busy ? "R7 lo" : {cur_tag, " lo"}, lo_out, m_lo);
      end
   end

   // called right after a falling edge; returns in the done cycle
   task automatic run_op(input string tag, input logic [1:0] c, input logic [31:0] a, input logic [31:0] b);
      cur_tag = tag;
      start = 1'b1; op = c; opa = a; opb = b;
      @(negedge clk);
      start = 1'b0;
      do @(negedge clk); while (!done);
   endtask

   task automatic stimulus();
      repeat (3) @(negedge clk);
      chk("R10 busy", {31'b0, busy}, 32'd0);
      chk("R10 done", {31'b0, done}, 32'd0);
      chk("R10 hi", hi_out, 32'd0);
      chk("R10 lo", lo_out, 32'd0);
      rst_n = 1'b1;
      running = 1'b1;
      @(negedge clk);
      chk("R10 idle hi", hi_out, 32'd0);
      run_op("R1", 2'b00, 32'd7, 32'd6);
      run_op("R1", 2'b00, 32'hFFFF_FFF9, 32'd6);
      run_op("R1", 2'b00, 32'h8000_0000, 32'h8000_0000);
      run_op("R1", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      run_op("R2", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      run_op("R2", 2'b01, 32'h8000_0000, 32'd2);
      run_op("R3", 2'b10, 32'd100, 32'd7);
      run_op("R3", 2'b10, 32'hFFFF_FF9C, 32'd7);
      run_op("R3", 2'b10, 32'd100, 32'hFFFF_FFF9);
      run_op("R3", 2'b10, 32'hFFFF_FF9C, 32'hFFFF_FFF9);
      run_op("R3", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
      run_op("R4", 2'b11, 32'hFFFF_FFFF, 32'd10);
      run_op("R4", 2'b11, 32'd5, 32'd9);
      run_op("R8", 2'b11, 32'h1234_5678, 32'd0);
      run_op("R9", 2'b10, 32'hF000_0001, 32'd0);
      run_op("R9", 2'b10, 32'd77, 32'd0);
      // R6: pulses during the busy window with different operands
      cur_tag = "R6";
      start = 1'b1; op = 2'b01; opa = 32'd3; opb = 32'd5;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      start = 1'b1; op = 2'b11; opa = 32'd999; opb = 32'd1;
      @(negedge clk);
      start = 1'b0;
      repeat (25) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      chk("R6 lo", lo_out, 32'd15);
      // R11: the previous call returned in the done cycle; this start is back to back
      run_op("R11", 2'b00, 32'd12345, 32'hFFFF_0000);
      @(negedge clk);
      repeat (3) @(negedge clk);
      for (int i = 0; i < 40; i++) begin
         logic [1:0] rc;
         rc = 2'($urandom_range(0, 3));
         run_op(rc[1] ? (rc[0] ? "R4" : "R3") : (rc[0] ? "R2" : "R1"), rc, $urandom, (i % 5 == 0) ? 32'($urandom_range(1, 300)) : $urandom);
         if (i % 3 == 0) @(negedge clk);
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      fork
         stimulus();
         begin
            repeat (150000) @(posedge clk);
            checks++;
            bad++;
            $display("FAIL watchdog expired at %0t", $time);
         end
      join_any
      disable fork;
      running = 1'b0;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule